// File: doc/BRIEF.md
# Oldest-Priority Unified Issue Scheduler

This block is the issue queue of one integer thread. It holds up to 40 micro-ops until both source operands are available and then hands them to four execution ports. There are two port classes: two arithmetic ports and two address-generation ports. An incoming micro-op takes the lowest-numbered free slot and keeps that slot until it issues. Slots never shift or compact.

A separate relative-age matrix tracks which valid entry is the single oldest. When that entry is ready, it goes first on its class's primary port. Every other choice ignores age and is made by slot number, lowest first. Result tags broadcast on the wakeup lanes mark matching sources ready, and the affected entries may issue in the following cycle. A flush empties the queue. When every slot is occupied, the allocate request is ignored and the ready output reports the stall.

Top module: `oldest_first_issue_queue`

## Requirements
- R1: While reset is held and right after it, no issue output is valid and `alloc_ready` is 1.
- R2: An accepted allocation lands in the lowest-numbered slot that is free in that cycle. `iss_slot` reports that slot number when the entry issues.
- R3: An entry allocated with both sources ready does not issue in its allocation cycle. It is eligible in the next cycle.
- R4: When the oldest valid entry is ready, it issues on the primary port of its class: port 0 for class 0, port 2 for class 1.
- R5: Every other issue slot of a class goes to ready entries of that class in ascending slot order, whatever their age. This applies to the primary port when the oldest entry is not ready or belongs to the other class, and to the secondary port (1 or 3) in all cases.
- R6: `alloc_cls` 0 (arithmetic) maps to ports 0 and 1, and 1 (address) maps to ports 2 and 3. In one cycle, no slot appears on two ports.
- R7: A wakeup lane whose valid bit is set and whose tag equals a stored source tag marks that source ready at the clock edge, so the entry may issue in the next cycle. A tag broadcast in the same cycle as the allocation of a micro-op that waits on it also counts.
- R8: `alloc_ready` is 0 exactly when all 40 slots are valid. A request made then is dropped and never issues.
- R9: While `flush` is 1, no issue output is valid. In the next cycle the queue is empty, and a micro-op offered together with the flush is dropped.
- R10: An issued entry leaves the queue at that clock edge. Its slot can be allocated from the next cycle on, and the entry never issues twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled at the edge |
| flush | input | 1 | Discard every entry |
| alloc_valid | input | 1 | Allocate request |
| alloc_op | input | OP_W | Micro-op payload |
| alloc_cls | input | 1 | Port class: 0 arithmetic, 1 address |
| alloc_tag_a | input | TAG_W | First source tag |
| alloc_rdy_a | input | 1 | First source already available |
| alloc_tag_b | input | TAG_W | Second source tag |
| alloc_rdy_b | input | 1 | Second source already available |
| alloc_ready | output | 1 | A free slot exists |
| wake_valid | input | WAKE_LANES | Per-lane result broadcast valid |
| wake_tag | input | WAKE_LANES*TAG_W | Per-lane result tags, lane 0 in the low bits |
| iss_valid | output | 4 | Per-port issue valid |
| iss_op | output | 4*OP_W | Per-port micro-op, port 0 in the low bits |
| iss_slot | output | 4*IDX_W | Per-port slot number, port 0 in the low bits |

## Verification
The issue outputs are decoded from stored state in the same cycle, so an allocation shows up on a port one cycle after its request. A wakeup shows up one cycle after its broadcast. A flush silences the ports at once and empties the queue by the next cycle. The bench drives every input just after the falling edge and compares the ports 1 ns later against a reference model advanced once per cycle. In that model, an entry's age is an allocation sequence number, not a matrix. Directed sequences pin the cycle in which each named result must appear, and a seeded random phase exercises mixes of classes, wakeups, full-queue stalls and flushes.

// File: rtl/ofiq_pkg.sv
package ofiq_pkg;
  localparam int unsigned DEF_ENTRIES   = 40;
  localparam int unsigned DEF_TAG_W     = 7;
  localparam int unsigned DEF_OP_W      = 16;
  localparam int unsigned DEF_WAKE      = 2;
  localparam int unsigned NUM_CLS       = 2;
  localparam int unsigned PORTS_PER_CLS = 2;
  typedef enum logic {CLS_ALU = 1'b0, CLS_AGU = 1'b1} port_cls_e;
endpackage

// File: rtl/ofiq_age_track.sv
module ofiq_age_track #(
  parameter int unsigned N = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         alloc_en,
  input  logic [N-1:0] alloc_onehot,
  input  logic [N-1:0] valid_vec,
  output logic [N-1:0] oldest_vec
);
  // older_q[i][j] = 1 : entry i entered before entry j
  logic [N-1:0] older_q [N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) older_q[i] <= '0;
    end else if (alloc_en) begin
      for (int i = 0; i < N; i++) begin
        for (int j = 0; j < N; j++) begin
          if (alloc_onehot[i])      older_q[i][j] <= 1'b0;
          else if (alloc_onehot[j]) older_q[i][j] <= 1'b1;
        end
      end
    end
  end

  for (genvar gi = 0; gi < N; gi++) begin : g_old
    logic [N-1:0] senior;
    always_comb begin
      senior = '0;
      for (int j = 0; j < N; j++)
        if (j != gi) senior[j] = older_q[j][gi];
    end
    assign oldest_vec[gi] = valid_vec[gi] & ~(|(senior & valid_vec));
  end

  // R4
  single_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(oldest_vec));
  // R4
  oldest_exists_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|valid_vec) |-> (|oldest_vec));
endmodule

// File: rtl/ofiq_slots.sv
module ofiq_slots #(
  parameter int unsigned N     = 40,
  parameter int unsigned TAG_W = 7,
  parameter int unsigned OP_W  = 16,
  parameter int unsigned NW    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              alloc_en,
  input  logic [N-1:0]      alloc_onehot,
  input  logic [OP_W-1:0]   alloc_op,
  input  logic              alloc_cls,
  input  logic [TAG_W-1:0]  alloc_tag_a,
  input  logic              alloc_rdy_a,
  input  logic [TAG_W-1:0]  alloc_tag_b,
  input  logic              alloc_rdy_b,
  input  logic [NW-1:0]     wake_valid,
  input  logic [NW*TAG_W-1:0] wake_tag,
  input  logic [N-1:0]      issue_clr,
  output logic [N-1:0]      valid_vec,
  output logic [N-1:0]      ready_vec,
  output logic [N-1:0]      cls_vec,
  output logic [N*OP_W-1:0] op_flat
);
  logic [N-1:0]      valid_q, rdy_a_q, rdy_b_q, cls_q;
  logic [OP_W-1:0]   op_q    [N];
  logic [TAG_W-1:0]  tag_a_q [N];
  logic [TAG_W-1:0]  tag_b_q [N];

  function automatic logic tag_hit(input logic [TAG_W-1:0] t,
                                   input logic [NW-1:0] wv,
                                   input logic [NW*TAG_W-1:0] wt);
    logic h;
    h = 1'b0;
    for (int l = 0; l < NW; l++)
      if (wv[l] && (wt[l*TAG_W +: TAG_W] == t)) h = 1'b1;
    return h;
  endfunction

  logic hit_new_a, hit_new_b;
  assign hit_new_a = tag_hit(alloc_tag_a, wake_valid, wake_tag);
  assign hit_new_b = tag_hit(alloc_tag_b, wake_valid, wake_tag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (flush) begin
      valid_q <= '0;
    end else begin
      valid_q <= (valid_q & ~issue_clr) | (alloc_en ? alloc_onehot : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_a_q <= '0;
      rdy_b_q <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (alloc_en && alloc_onehot[i]) begin
          rdy_a_q[i] <= alloc_rdy_a | hit_new_a;
          rdy_b_q[i] <= alloc_rdy_b | hit_new_b;
        end else begin
          if (tag_hit(tag_a_q[i], wake_valid, wake_tag)) rdy_a_q[i] <= 1'b1;
          if (tag_hit(tag_b_q[i], wake_valid, wake_tag)) rdy_b_q[i] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cls_q <= '0;
      for (int i = 0; i < N; i++) begin
        op_q[i]    <= '0;
        tag_a_q[i] <= '0;
        tag_b_q[i] <= '0;
      end
    end else if (alloc_en) begin
      for (int i = 0; i < N; i++) begin
        if (alloc_onehot[i]) begin
          op_q[i]    <= alloc_op;
          tag_a_q[i] <= alloc_tag_a;
          tag_b_q[i] <= alloc_tag_b;
          cls_q[i]   <= alloc_cls;
        end
      end
    end
  end

  assign valid_vec = valid_q;
  assign ready_vec = valid_q & rdy_a_q & rdy_b_q;
  assign cls_vec   = cls_q;
  for (genvar gi = 0; gi < N; gi++) begin : g_op
    assign op_flat[gi*OP_W +: OP_W] = op_q[gi];

    // R7
    wake_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q[gi] && tag_hit(tag_a_q[gi], wake_valid, wake_tag) |=> rdy_a_q[gi]);
  end
endmodule

// File: rtl/ofiq_class_pick.sv
module ofiq_class_pick #(
  parameter int unsigned N     = 40,
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     cand,
  input  logic [N-1:0]     oldest,
  output logic             a_vld,
  output logic [IDX_W-1:0] a_idx,
  output logic             b_vld,
  output logic [IDX_W-1:0] b_idx,
  output logic [N-1:0]     pick_mask
);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  function automatic logic [N-1:0] lowest_bit(input logic [N-1:0] v);
    return v & (~v + ONE);
  endfunction

  function automatic logic [IDX_W-1:0] onehot_idx(input logic [N-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < N; i++)
      if (v[i]) r = r | IDX_W'(i);
    return r;
  endfunction

  logic [N-1:0] oldest_hit, first_vec, second_vec;

  assign oldest_hit = cand & oldest;
  assign first_vec  = (|oldest_hit) ? oldest_hit : lowest_bit(cand);
  assign second_vec = lowest_bit(cand & ~first_vec);

  assign a_vld     = |first_vec;
  assign b_vld     = |second_vec;
  assign a_idx     = onehot_idx(first_vec);
  assign b_idx     = onehot_idx(second_vec);
  assign pick_mask = first_vec | second_vec;

  // R6
  distinct_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_vld && b_vld |-> a_idx != b_idx);
  // R5
  primary_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b_vld |-> a_vld);
endmodule

// File: rtl/oldest_first_issue_queue.sv
module oldest_first_issue_queue
  import ofiq_pkg::*;
#(
  parameter  int unsigned ENTRIES    = DEF_ENTRIES,
  parameter  int unsigned TAG_W      = DEF_TAG_W,
  parameter  int unsigned OP_W       = DEF_OP_W,
  parameter  int unsigned WAKE_LANES = DEF_WAKE,
  localparam int unsigned IDX_W      = $clog2(ENTRIES),
  localparam int unsigned NUM_PORTS  = NUM_CLS * PORTS_PER_CLS
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flush,
  input  logic                        alloc_valid,
  input  logic [OP_W-1:0]             alloc_op,
  input  logic                        alloc_cls,
  input  logic [TAG_W-1:0]            alloc_tag_a,
  input  logic                        alloc_rdy_a,
  input  logic [TAG_W-1:0]            alloc_tag_b,
  input  logic                        alloc_rdy_b,
  output logic                        alloc_ready,
  input  logic [WAKE_LANES-1:0]       wake_valid,
  input  logic [WAKE_LANES*TAG_W-1:0] wake_tag,
  output logic [NUM_PORTS-1:0]        iss_valid,
  output logic [NUM_PORTS*OP_W-1:0]   iss_op,
  output logic [NUM_PORTS*IDX_W-1:0]  iss_slot
);
  localparam logic [ENTRIES-1:0] ONE = {{(ENTRIES-1){1'b0}}, 1'b1};

  function automatic logic [ENTRIES-1:0] lowest_bit(input logic [ENTRIES-1:0] v);
    return v & (~v + ONE);
  endfunction

  logic [ENTRIES-1:0]      valid_vec, ready_vec, cls_vec, oldest_vec;
  logic [ENTRIES-1:0]      free_vec, alloc_onehot, issue_clr;
  logic [ENTRIES*OP_W-1:0] op_flat;
  logic                    alloc_en;
  logic [NUM_PORTS-1:0]    pick_v;
  logic [IDX_W-1:0]        pick_idx [NUM_PORTS];
  logic [ENTRIES-1:0]      cls_mask [NUM_CLS];

  assign free_vec     = ~valid_vec;
  assign alloc_onehot = lowest_bit(free_vec);
  assign alloc_ready  = |free_vec;
  assign alloc_en     = alloc_valid & alloc_ready & ~flush;

  ofiq_slots #(.N(ENTRIES), .TAG_W(TAG_W), .OP_W(OP_W), .NW(WAKE_LANES)) u_slots (
    .clk, .rst_n, .flush, .alloc_en, .alloc_onehot,
    .alloc_op, .alloc_cls, .alloc_tag_a, .alloc_rdy_a, .alloc_tag_b, .alloc_rdy_b,
    .wake_valid, .wake_tag, .issue_clr,
    .valid_vec, .ready_vec, .cls_vec, .op_flat
  );

  ofiq_age_track #(.N(ENTRIES)) u_age (
    .clk, .rst_n, .alloc_en, .alloc_onehot, .valid_vec, .oldest_vec
  );

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    logic [ENTRIES-1:0] cand;
    logic               a_vld, b_vld;
    logic [IDX_W-1:0]   a_idx, b_idx;
    assign cand = ready_vec & ((c == int'(CLS_ALU)) ? ~cls_vec : cls_vec);
    ofiq_class_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick (
      .clk, .rst_n, .cand, .oldest(oldest_vec),
      .a_vld, .a_idx, .b_vld, .b_idx, .pick_mask(cls_mask[c])
    );
    assign pick_v[c*PORTS_PER_CLS]       = a_vld;
    assign pick_v[c*PORTS_PER_CLS + 1]   = b_vld;
    assign pick_idx[c*PORTS_PER_CLS]     = a_idx;
    assign pick_idx[c*PORTS_PER_CLS + 1] = b_idx;
  end

  always_comb begin
    issue_clr = '0;
    for (int c = 0; c < NUM_CLS; c++) issue_clr = issue_clr | cls_mask[c];
    if (flush) issue_clr = '0;
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign iss_valid[p]                = pick_v[p] & ~flush;
    assign iss_slot[p*IDX_W +: IDX_W]  = pick_idx[p];
    assign iss_op[p*OP_W +: OP_W]      = op_flat[pick_idx[p]*OP_W +: OP_W];
  end

  // R9
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (iss_valid == '0) && alloc_ready);
  // R8
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_ready && !(|iss_valid) && !flush |=> !alloc_ready);
  // R10
  slot_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|iss_valid) |=> alloc_ready);
  // R4
  oldest_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flush && (|(oldest_vec & ready_vec)) |=> ((valid_vec & $past(oldest_vec & ready_vec)) == '0));
endmodule

// File: tb/oldest_first_issue_queue_test.sv
module oldest_first_issue_queue_test;
  localparam int N  = 40;
  localparam int TW = 7;
  localparam int OW = 16;
  localparam int NW = 2;
  localparam int IW = $clog2(N);
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic flush, alloc_valid, alloc_cls, alloc_rdy_a, alloc_rdy_b, alloc_ready;
  logic [OW-1:0] alloc_op;
  logic [TW-1:0] alloc_tag_a, alloc_tag_b;
  logic [NW-1:0] wake_valid;
  logic [NW*TW-1:0] wake_tag;
  logic [NP-1:0] iss_valid;
  logic [NP*OW-1:0] iss_op;
  logic [NP*IW-1:0] iss_slot;

  oldest_first_issue_queue uut (
    .clk, .rst_n, .flush, .alloc_valid, .alloc_op, .alloc_cls,
    .alloc_tag_a, .alloc_rdy_a, .alloc_tag_b, .alloc_rdy_b, .alloc_ready,
    .wake_valid, .wake_tag, .iss_valid, .iss_op, .iss_slot
  );

  int checks = 0;
  int errors = 0;
  bit m_vld[N];
  bit m_ra[N];
  bit m_rb[N];
  bit m_cls[N];
  int m_op[N];
  int m_ta[N];
  int m_tb[N];
  int m_seq[N];
  int next_seq = 0;
  bit exp_v[NP];
  int exp_s[NP];
  int oldest;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit hit(input int t);
    return (wake_valid[0] && wake_tag[TW-1:0] == t[TW-1:0]) ||
           (wake_valid[1] && wake_tag[2*TW-1:TW] == t[TW-1:0]);
  endfunction

  function automatic int first_free();
    for (int i = 0; i < N; i++) if (!m_vld[i]) return i;
    return -1;
  endfunction

  function automatic int slot_of(input int p);
    return int'(iss_slot[p*IW +: IW]);
  endfunction

  function automatic int op_of(input int p);
    return int'(iss_op[p*OW +: OW]);
  endfunction

  task automatic compute_exp();
    int best;
    best = 32'h7fffffff;
    oldest = -1;
    for (int i = 0; i < N; i++)
      if (m_vld[i] && m_seq[i] < best) begin best = m_seq[i]; oldest = i; end
    for (int c = 0; c < 2; c++) begin
      int a, b;
      a = -1; b = -1;
      if (oldest >= 0 && m_ra[oldest] && m_rb[oldest] && int'(m_cls[oldest]) == c) a = oldest;
      for (int i = 0; i < N; i++)
        if (m_vld[i] && m_ra[i] && m_rb[i] && int'(m_cls[i]) == c && i != a) begin
          if (a < 0) a = i;
          else if (b < 0) b = i;
        end
      exp_v[2*c]   = (a >= 0) && !flush;
      exp_s[2*c]   = a;
      exp_v[2*c+1] = (b >= 0) && !flush;
      exp_s[2*c+1] = b;
    end
  endtask

  task automatic set_idle();
    flush = 0; alloc_valid = 0; alloc_op = '0; alloc_cls = 0;
    alloc_tag_a = '0; alloc_rdy_a = 0; alloc_tag_b = '0; alloc_rdy_b = 0;
    wake_valid = '0; wake_tag = '0;
  endtask

  task automatic do_alloc(input int op, input bit cls, input int ta, input bit ra,
                          input int tb, input bit rb);
    alloc_valid = 1; alloc_op = OW'(op); alloc_cls = cls;
    alloc_tag_a = TW'(ta); alloc_rdy_a = ra; alloc_tag_b = TW'(tb); alloc_rdy_b = rb;
  endtask

  task automatic set_wake(input int lane, input int tag);
    wake_valid[lane] = 1'b1;
    wake_tag[lane*TW +: TW] = TW'(tag);
  endtask

  task automatic begin_cycle();
    @(negedge clk);
    set_idle();
  endtask

  task automatic eval();
    int nv;
    #1;
    compute_exp();
    chk(alloc_ready === (first_free() >= 0), "R8 alloc_ready", int'(alloc_ready), int'(first_free() >= 0));
    nv = 0;
    for (int p = 0; p < NP; p++) begin
      string tag;
      tag = (p % 2 == 0 && exp_s[p] == oldest) ? "R4 issue" : "R5 issue";
      chk(iss_valid[p] === exp_v[p], tag, int'(iss_valid[p]), int'(exp_v[p]));
      if (exp_v[p] && iss_valid[p]) begin
        nv++;
        chk(slot_of(p) == exp_s[p], tag, slot_of(p), exp_s[p]);
        chk(op_of(p) == m_op[exp_s[p]], tag, op_of(p), m_op[exp_s[p]]);
      end
    end
    if (nv > 1)
      for (int p = 0; p < NP; p++)
        for (int q = p + 1; q < NP; q++)
          if (iss_valid[p] && iss_valid[q])
            chk(slot_of(p) != slot_of(q), "R6 distinct slots", slot_of(p), -1);
  endtask

  task automatic commit();
    int k;
    k = first_free();
    for (int i = 0; i < N; i++) begin
      if (hit(m_ta[i])) m_ra[i] = 1;
      if (hit(m_tb[i])) m_rb[i] = 1;
    end
    if (flush) begin
      for (int i = 0; i < N; i++) m_vld[i] = 0;
    end else begin
      for (int p = 0; p < NP; p++) if (exp_v[p]) m_vld[exp_s[p]] = 0;
      if (alloc_valid && k >= 0) begin
        m_vld[k] = 1; m_op[k] = int'(alloc_op); m_cls[k] = alloc_cls;
        m_ta[k] = int'(alloc_tag_a); m_tb[k] = int'(alloc_tag_b);
        m_ra[k] = alloc_rdy_a || hit(int'(alloc_tag_a));
        m_rb[k] = alloc_rdy_b || hit(int'(alloc_tag_b));
        m_seq[k] = next_seq; next_seq++;
      end
    end
  endtask

  task automatic idle_cycle();
    begin_cycle(); eval(); commit();
  endtask

  task automatic port_chk(input string req, input int p, input int slot, input int op);
    chk(iss_valid[p] === 1'b1, req, int'(iss_valid[p]), 1);
    chk(slot_of(p) == slot, req, slot_of(p), slot);
    chk(op_of(p) == op, req, op_of(p), op);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd12345));
    set_idle();
    for (int i = 0; i < N; i++) begin
      m_vld[i] = 0; m_ra[i] = 0; m_rb[i] = 0; m_cls[i] = 0;
      m_op[i] = 0; m_ta[i] = 0; m_tb[i] = 0; m_seq[i] = 0;
    end
    repeat (3) @(negedge clk);
    #1;
    // R1 during reset
    chk(iss_valid === '0, "R1 reset issue", int'(iss_valid), 0);
    chk(alloc_ready === 1'b1, "R1 reset ready", int'(alloc_ready), 1);
    @(negedge clk);
    rst_n = 1;
    begin_cycle(); eval();
    chk(iss_valid === '0, "R1 after reset", int'(iss_valid), 0);
    commit();

    // R2 / R3 : allocation then issue one cycle later
    begin_cycle(); do_alloc('h100, 0, 0, 1, 0, 1); eval();
    chk(iss_valid === '0, "R3 same cycle", int'(iss_valid), 0);
    commit();
    begin_cycle(); eval();
    port_chk("R2 R3 first issue", 0, 0, 'h100);
    commit();
    begin_cycle(); eval();
    chk(iss_valid === '0, "R10 no reissue", int'(iss_valid), 0);
    commit();

    // R4 / R5 / R7 ordering scenario
    begin_cycle(); do_alloc('h200, 0, 1, 0, 0, 1); eval(); commit();
    begin_cycle(); do_alloc('h201, 0, 2, 0, 0, 1); eval(); commit();
    begin_cycle(); do_alloc('h202, 0, 3, 0, 0, 1); eval(); commit();
    begin_cycle(); set_wake(0, 1); eval(); commit();
    begin_cycle(); eval(); port_chk("R7 wake issue", 0, 0, 'h200); commit();
    begin_cycle(); do_alloc('h203, 0, 4, 0, 0, 1); eval(); commit();
    begin_cycle(); set_wake(0, 4); set_wake(1, 3); eval(); commit();
    begin_cycle(); eval();
    port_chk("R5 slot order primary", 0, 0, 'h203);
    port_chk("R5 slot order secondary", 1, 2, 'h202);
    commit();
    begin_cycle(); do_alloc('h204, 0, 0, 1, 0, 1); set_wake(0, 2); eval(); commit();
    begin_cycle(); eval();
    port_chk("R4 oldest first", 0, 1, 'h201);
    port_chk("R5 younger lower slot", 1, 0, 'h204);
    commit();
    begin_cycle(); do_alloc('h205, 0, 7, 0, 0, 1); set_wake(1, 7); eval(); commit();
    begin_cycle(); do_alloc('h206, 1, 0, 1, 0, 1); eval();
    port_chk("R7 same-cycle wake", 0, 0, 'h205);
    commit();
    begin_cycle(); eval();
    port_chk("R6 address class", 2, 1, 'h206);
    chk(iss_valid[1:0] === 2'b00, "R6 arithmetic ports idle", int'(iss_valid[1:0]), 0);
    commit();

    // R8 / R10 full queue
    begin_cycle(); flush = 1; eval(); commit();
    for (int i = 0; i < N; i++) begin
      begin_cycle(); do_alloc('h300 + i, 0, 20, 0, 0, 1); eval(); commit();
    end
    begin_cycle(); do_alloc('hDEAD, 0, 0, 1, 0, 1); eval();
    chk(alloc_ready === 1'b0, "R8 full", int'(alloc_ready), 0);
    commit();
    begin_cycle(); set_wake(0, 20); eval(); commit();
    begin_cycle(); eval();
    port_chk("R4 oldest of full", 0, 0, 'h300);
    port_chk("R8 dropped request absent", 1, 1, 'h301);
    commit();
    begin_cycle(); eval();
    chk(alloc_ready === 1'b1, "R10 slot freed", int'(alloc_ready), 1);
    commit();

    // R9 flush
    begin_cycle(); flush = 1; do_alloc('hBEEF, 0, 0, 1, 0, 1); eval();
    chk(iss_valid === '0, "R9 flush cycle quiet", int'(iss_valid), 0);
    commit();
    begin_cycle(); eval();
    chk(iss_valid === '0, "R9 empty after flush", int'(iss_valid), 0);
    chk(alloc_ready === 1'b1, "R9 ready after flush", int'(alloc_ready), 1);
    commit();
    idle_cycle();

    // random phase
    for (int cyc = 0; cyc < 4000; cyc++) begin
      begin_cycle();
      if ($urandom_range(99) < 70)
        do_alloc('h1000 + cyc, 1'($urandom_range(1)), int'($urandom_range(15)),
                 1'($urandom_range(1)), int'($urandom_range(15)), 1'($urandom_range(1)));
      if ($urandom_range(99) < 45) set_wake(0, int'($urandom_range(15)));
      if ($urandom_range(99) < 45) set_wake(1, int'($urandom_range(15)));
      if ($urandom_range(299) == 0) flush = 1;
      eval();
      commit();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule